// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block gathers a set of level-sensitive peripheral interrupt inputs and folds them onto a smaller group of CPU interrupt lines. Each source has an enable bit and a small routing field that names the CPU line it drives. Any number of sources may share one line. A CPU line is high for as long as at least one source routed to it is both enabled and active. Because the inputs are levels, the status view shows the raw input levels. Nothing is latched, so nothing needs clearing.

Software reaches the block through a plain register port. A single-cycle request is marked by `reg_valid` and its direction by `reg_write`. The port has no back-pressure, so every request is accepted in the cycle it is presented. Read data is registered. It appears in the cycle after the request and holds until the next read. To service an interrupt, software reads the enable word and the status word, ANDs them, and picks a pending source itself.

The CPU outputs are registered. A write to the enable or routing registers takes effect on the same clock edge that stores it, so clearing the enable word drops every output on that edge.

Top module: `route_irq_ctrl`

## Requirements
- R1: After reset, `cpu_irq` is 0, `reg_rdata` is 0, and the enable word and all routing words read back as 0.
- R2: The enable word sits at byte offset 0x00. It can be read and written, and bit n set to 1 enables source n.
- R3: The status word at offset 0x04 reads the raw level of source n in bit n. A write to 0x04 changes no register and no output.
- R4: Four routing words sit at offsets 0x08, 0x0C, 0x10 and 0x14. Each holds eight 4-bit fields and reads back what was written. Offset 0x14 holds sources 0–7, 0x10 holds sources 8–15, 0x0C holds sources 16–23 and 0x08 holds sources 24–31. Source n uses bits [4*(n mod 8)+3 : 4*(n mod 8)].
- R5: One clock after the inputs are sampled, `cpu_irq[k]` is the OR over all sources n that are enabled, active and have a routing field equal to k.
- R6: When several sources share a line, the line stays high until the last of them goes inactive.
- R7: A routing field of 8 to 15 connects the source to no CPU line.
- R8: Writing 0 to the enable word forces every `cpu_irq` bit to 0 on the clock edge that stores the write.
- R9: A read of any offset other than 0x00 to 0x14 returns 0. A write to such an offset changes no register.
- R10: `reg_rdata` takes the read result on the clock edge that accepts a read request. It keeps that value while no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | 32 | Level-sensitive interrupt inputs, one per source |
| reg_valid | input | 1 | Register request, one cycle per access |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset; bits [1:0] are ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| cpu_irq | output | 8 | Registered CPU interrupt lines |

## Verification
The bench builds the block with its default parameters: 32 sources, 8 CPU lines and 4-bit routing fields. With these values the routing fields can also hold codes from 8 to 15, which connect to no line, so the no-route codes can be tested. All four routing words exist, so the reversed address order of the words can be checked from both ends. A scoreboard in the bench decodes the routing words by offset, independently of the design, and predicts each CPU line for many patterns of enables and input levels.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned BUS_W = 32;
  // word index inside the register window (byte offset / 4)
  localparam int unsigned WORD_EN    = 0;
  localparam int unsigned WORD_LVL   = 1;
  localparam int unsigned WORD_ROUTE = 2;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_EN    = 2'd1,
    SEL_LVL   = 2'd2,
    SEL_ROUTE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_route_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned N_RWORDS = 4,
  localparam int unsigned GRP_W   = (N_RWORDS > 1) ? $clog2(N_RWORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [GRP_W-1:0]  grp
);
  int unsigned word;

  always_comb begin
    word = int'(addr[ADDR_W-1:2]);
    sel  = SEL_NONE;
    grp  = '0;
    if (word == WORD_EN) begin
      sel = SEL_EN;
    end else if (word == WORD_LVL) begin
      sel = SEL_LVL;
    end else if (word >= WORD_ROUTE && word < WORD_ROUTE + N_RWORDS) begin
      sel = SEL_ROUTE;
      // lowest offset carries the highest-numbered group of sources
      grp = GRP_W'(N_RWORDS - 1 - (word - WORD_ROUTE));
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned N_SRC    = 32,
  parameter int unsigned ROUTE_W  = 4,
  localparam int unsigned PER_WORD = BUS_W / ROUTE_W,
  localparam int unsigned N_RWORDS = N_SRC / PER_WORD,
  localparam int unsigned GRP_W    = (N_RWORDS > 1) ? $clog2(N_RWORDS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  reg_sel_e                 sel,
  input  logic [GRP_W-1:0]         grp,
  input  logic [BUS_W-1:0]         wdata,
  input  logic [N_SRC-1:0]         src_lvl,
  output logic [N_SRC-1:0]         en_q,
  output logic [N_SRC-1:0]         en_nxt,
  output logic [N_SRC*ROUTE_W-1:0] route_q,
  output logic [N_SRC*ROUTE_W-1:0] route_nxt,
  output logic [BUS_W-1:0]         rdata
);
  logic             wr;
  logic [BUS_W-1:0] rd_mux;
  logic [BUS_W-1:0] en_ext;
  logic [BUS_W-1:0] lvl_ext;

  assign wr = req_valid && req_write;

  always_comb begin
    en_nxt = en_q;
    if (wr && sel == SEL_EN) en_nxt = wdata[N_SRC-1:0];
  end

  generate
    for (genvar g = 0; g < N_RWORDS; g++) begin : g_rword
      always_comb begin
        route_nxt[g*BUS_W +: BUS_W] = route_q[g*BUS_W +: BUS_W];
        if (wr && sel == SEL_ROUTE && grp == GRP_W'(g))
          route_nxt[g*BUS_W +: BUS_W] = wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
    end else begin
      en_q    <= en_nxt;
      route_q <= route_nxt;
    end
  end

  always_comb begin
    en_ext  = '0;
    lvl_ext = '0;
    en_ext[N_SRC-1:0]  = en_q;
    lvl_ext[N_SRC-1:0] = src_lvl;
    unique case (sel)
      SEL_EN:    rd_mux = en_ext;
      SEL_LVL:   rd_mux = lvl_ext;
      SEL_ROUTE: rd_mux = route_q[int'(grp)*BUS_W +: BUS_W];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      rdata <= '0;
    else if (req_valid && !req_write) rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix #(
  parameter int unsigned N_SRC   = 32,
  parameter int unsigned N_CPU   = 8,
  parameter int unsigned ROUTE_W = 4
) (
  input  logic [N_SRC-1:0]         src_lvl,
  input  logic [N_SRC-1:0]         en,
  input  logic [N_SRC*ROUTE_W-1:0] route,
  output logic [N_CPU-1:0]         line
);
  logic [N_SRC-1:0] live;
  assign live = src_lvl & en;

  generate
    for (genvar k = 0; k < N_CPU; k++) begin : g_line
      logic [N_SRC-1:0] hit;
      for (genvar n = 0; n < N_SRC; n++) begin : g_src
        // full-width compare: codes at or above N_CPU match no line
        assign hit[n] = live[n] && (route[n*ROUTE_W +: ROUTE_W] == ROUTE_W'(k));
      end
      assign line[k] = |hit;
    end
  endgenerate
endmodule

// File: rtl/route_irq_ctrl.sv
module route_irq_ctrl
  import irq_route_pkg::*;
#(
  parameter int unsigned N_SRC   = 32,
  parameter int unsigned N_CPU   = 8,
  parameter int unsigned ROUTE_W = 4,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_lvl,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic [N_CPU-1:0]  cpu_irq
);
  localparam int unsigned PER_WORD = BUS_W / ROUTE_W;
  localparam int unsigned N_RWORDS = N_SRC / PER_WORD;
  localparam int unsigned GRP_W    = (N_RWORDS > 1) ? $clog2(N_RWORDS) : 1;

  reg_sel_e                 sel;
  logic [GRP_W-1:0]         grp;
  logic [N_SRC-1:0]         en_q;
  logic [N_SRC-1:0]         en_nxt;
  logic [N_SRC*ROUTE_W-1:0] route_q;
  logic [N_SRC*ROUTE_W-1:0] route_nxt;
  logic [N_CPU-1:0]         line_d;

  irq_addr_decode #(.ADDR_W(ADDR_W), .N_RWORDS(N_RWORDS)) u_dec (
    .addr(reg_addr), .sel(sel), .grp(grp)
  );

  irq_regs #(.N_SRC(N_SRC), .ROUTE_W(ROUTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(reg_valid), .req_write(reg_write),
    .sel(sel), .grp(grp), .wdata(reg_wdata), .src_lvl(src_lvl),
    .en_q(en_q), .en_nxt(en_nxt), .route_q(route_q), .route_nxt(route_nxt),
    .rdata(reg_rdata)
  );

  // settings being stored this edge feed the output register directly
  irq_route_matrix #(.N_SRC(N_SRC), .N_CPU(N_CPU), .ROUTE_W(ROUTE_W)) u_mtx (
    .src_lvl(src_lvl), .en(en_nxt), .route(route_nxt), .line(line_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cpu_irq <= '0;
    else        cpu_irq <= line_d;
  end
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int unsigned N_SRC   = 32,
  parameter int unsigned N_CPU   = 8,
  parameter int unsigned ROUTE_W = 4,
  parameter int unsigned ADDR_W  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_SRC-1:0]         src_lvl,
  input logic                     reg_valid,
  input logic                     reg_write,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic [31:0]              reg_wdata,
  input logic [31:0]              reg_rdata,
  input logic [N_CPU-1:0]         cpu_irq,
  input logic [N_SRC-1:0]         en_q,
  input logic [N_SRC*ROUTE_W-1:0] route_q
);
  localparam int unsigned TOP_WORD = 2 + (N_SRC * ROUTE_W) / 32;
  logic wr_any;
  int unsigned word;
  assign wr_any = reg_valid && reg_write;
  assign word   = int'(reg_addr[ADDR_W-1:2]);

  // R5
  quiet_in_quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_lvl == '0) |=> (cpu_irq == '0));

  // R8
  mask_clear_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && word == 0 && reg_wdata[N_SRC-1:0] == '0) |=> (cpu_irq == '0));

  // R3
  status_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && word == 1) |=> ($stable(en_q) && $stable(route_q)));

  // R9
  unmapped_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && word >= TOP_WORD) |=> ($stable(en_q) && $stable(route_q)));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_valid && !reg_write) |=> $stable(reg_rdata));
endmodule

bind route_irq_ctrl irq_route_chk #(
  .N_SRC(N_SRC), .N_CPU(N_CPU), .ROUTE_W(ROUTE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .reg_valid(reg_valid),
  .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .cpu_irq(cpu_irq), .en_q(en_q), .route_q(route_q)
);

// File: tb/route_irq_ctrl_bench.sv
module route_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lvl = '0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  cpu_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_en = '0;
  logic [3:0]  m_route [32];

  always #5 clk = ~clk;

  route_irq_ctrl u_route_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .reg_valid(reg_valid),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] predict(input logic [31:0] src);
    logic [7:0] r = '0;
    for (int n = 0; n < 32; n++)
      if (m_en[n] && src[n] && m_route[n] < 4'd8) r[m_route[n][2:0]] = 1'b1;
    return r;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
    if (a == 8'h00) m_en = d;
    if (a >= 8'h08 && a <= 8'h14 && a[1:0] == 2'b00) begin
      int g = 3 - (int'(a) - 8) / 4;
      for (int j = 0; j < 8; j++) m_route[8*g + j] = d[4*j +: 4];
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_valid = 1'b0;
    d = reg_rdata;
  endtask

  task automatic drive_and_check(input string req, input logic [31:0] s);
    src_lvl = s;
    @(posedge clk); @(negedge clk);
    check(req, {24'h0, cpu_irq}, {24'h0, predict(s)});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 cpu_irq", {24'h0, cpu_irq}, 32'h0);
    check("R1 rdata", reg_rdata, 32'h0);
    rd(8'h00, d); check("R1 enable word", d, 32'h0);
    for (int a = 8; a <= 20; a += 4) begin
      rd(8'(a), d); check("R1 route word", d, 32'h0);
    end
  endtask

  task automatic t_enable_rw();
    logic [31:0] d;
    wr(8'h00, 32'hA5A5_0F0F);
    rd(8'h00, d); check("R2 enable readback", d, 32'hA5A5_0F0F);
    // route all to line 0, only enabled sources drive it
    wr(8'h14, 32'h0); wr(8'h10, 32'h0); wr(8'h0C, 32'h0); wr(8'h08, 32'h0);
    wr(8'h00, 32'h0000_0004);
    drive_and_check("R2 disabled source silent", 32'h0000_0008);
    drive_and_check("R2 enabled source drives", 32'h0000_000C);
    src_lvl = '0;
  endtask

  task automatic t_route_layout();
    logic [31:0] d;
    wr(8'h14, 32'h7654_3210); wr(8'h10, 32'h0123_4567);
    wr(8'h0C, 32'h89AB_CDEF); wr(8'h08, 32'h1F2E_3D4C);
    rd(8'h14, d); check("R4 word 0x14", d, 32'h7654_3210);
    rd(8'h10, d); check("R4 word 0x10", d, 32'h0123_4567);
    rd(8'h0C, d); check("R4 word 0x0C", d, 32'h89AB_CDEF);
    rd(8'h08, d); check("R4 word 0x08", d, 32'h1F2E_3D4C);
    wr(8'h00, 32'hFFFF_FFFF);
    // source 3 -> line 3 (0x14), source 8 -> line 7 (0x10), source 31 -> line 1 (0x08)
    src_lvl = 32'h0000_0008; @(posedge clk); @(negedge clk);
    check("R4 source 3 on line 3", {24'h0, cpu_irq}, 32'h08);
    src_lvl = 32'h0000_0100; @(posedge clk); @(negedge clk);
    check("R4 source 8 on line 7", {24'h0, cpu_irq}, 32'h80);
    src_lvl = 32'h8000_0000; @(posedge clk); @(negedge clk);
    check("R4 source 31 on line 1", {24'h0, cpu_irq}, 32'h02);
    src_lvl = '0;
  endtask

  task automatic t_status();
    logic [31:0] d;
    src_lvl = 32'hDEAD_BEEF;
    rd(8'h04, d); check("R3 status raw", d, 32'hDEAD_BEEF);
    wr(8'h00, 32'h0F0F_0F0F);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R3 status write leaves enable", d, 32'h0F0F_0F0F);
    rd(8'h14, d); check("R3 status write leaves routes", d, 32'h7654_3210);
    src_lvl = 32'h1234_5678;
    rd(8'h04, d); check("R3 status follows level", d, 32'h1234_5678);
    src_lvl = '0;
  endtask

  task automatic t_routing();
    wr(8'h14, 32'h7654_3210); wr(8'h10, 32'h0123_4567);
    wr(8'h0C, 32'h89AB_3210); wr(8'h08, 32'h5566_7711);
    wr(8'h00, 32'hF0F0_FFFF);
    drive_and_check("R5 pattern a", 32'h0000_00FF);
    drive_and_check("R5 pattern b", 32'hFFFF_0000);
    drive_and_check("R5 pattern c", 32'h8421_8421);
    drive_and_check("R5 pattern d", 32'hFFFF_FFFF);
    drive_and_check("R5 pattern e", 32'h0000_0000);
    drive_and_check("R5 pattern f", 32'h5A5A_A5A5);
    src_lvl = '0;
  endtask

  task automatic t_shared();
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FF5F); wr(8'h10, 32'hFFFF_FF5F);
    wr(8'h0C, 32'hFFFF_FF5F); wr(8'h08, 32'hFFFF_FFFF);
    src_lvl = 32'h0002_0202; @(posedge clk); @(negedge clk);
    check("R6 three sharers", {24'h0, cpu_irq}, 32'h20);
    src_lvl = 32'h0002_0200; @(posedge clk); @(negedge clk);
    check("R6 two sharers", {24'h0, cpu_irq}, 32'h20);
    src_lvl = 32'h0002_0000; @(posedge clk); @(negedge clk);
    check("R6 last sharer", {24'h0, cpu_irq}, 32'h20);
    src_lvl = 32'h0; @(posedge clk); @(negedge clk);
    check("R6 all gone", {24'h0, cpu_irq}, 32'h00);
  endtask

  task automatic t_nowhere();
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_F7F8);
    wr(8'h10, 32'h9999_9999); wr(8'h0C, 32'hAAAA_AAAA); wr(8'h08, 32'hFFFF_FFFF);
    src_lvl = 32'hFFFF_FFFB; @(posedge clk); @(negedge clk);
    check("R7 codes 8..15 route nowhere", {24'h0, cpu_irq}, 32'h00);
    src_lvl = 32'hFFFF_FFFF; @(posedge clk); @(negedge clk);
    check("R7 code 7 still routes", {24'h0, cpu_irq}, 32'h80);
    src_lvl = '0;
  endtask

  task automatic t_mask_kill();
    wr(8'h14, 32'h7654_3210); wr(8'h10, 32'h7654_3210);
    wr(8'h0C, 32'h7654_3210); wr(8'h08, 32'h7654_3210);
    wr(8'h00, 32'hFFFF_FFFF);
    src_lvl = 32'hFFFF_FFFF; @(posedge clk); @(negedge clk);
    check("R8 lines up before clear", {24'h0, cpu_irq}, 32'hFF);
    wr(8'h00, 32'h0);
    check("R8 lines down on write edge", {24'h0, cpu_irq}, 32'h00);
    src_lvl = '0;
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h00, 32'h3333_CCCC);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd(8'h18, d); check("R9 read 0x18", d, 32'h0);
    rd(8'h40, d); check("R9 read 0x40", d, 32'h0);
    rd(8'h00, d); check("R9 enable untouched", d, 32'h3333_CCCC);
    rd(8'h08, d); check("R9 route untouched", d, 32'h7654_3210);
  endtask

  task automatic t_read_timing();
    logic [31:0] d;
    src_lvl = '0;
    rd(8'h04, d); check("R10 status zero", d, 32'h0);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = 8'h00;
    #2; check("R10 old value before edge", reg_rdata, 32'h0);
    @(posedge clk); @(negedge clk);
    reg_valid = 1'b0;
    check("R10 new value after edge", reg_rdata, 32'h3333_CCCC);
    src_lvl = 32'hFFFF_0000; reg_addr = 8'h04;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    check("R10 held without request", reg_rdata, 32'h3333_CCCC);
    src_lvl = '0;
  endtask

  initial begin
    for (int n = 0; n < 32; n++) m_route[n] = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_enable_rw();
    t_route_layout();
    t_status();
    t_routing();
    t_shared();
    t_nowhere();
    t_mask_kill();
    t_unmapped();
    t_read_timing();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule